// File: doc/BRIEF.md
# DSP Address Generator

This block produces one memory address per enabled clock cycle for a single local data memory that is 16 bits wide and 1024 words deep. It walks through the memory with a fixed step up or down, or in bit-reversed order for FFT data shuffles. It also has a table mode, in which a 16-bit data word chooses the entry, so that the memory can serve precomputed function values such as a sine table or a division by a constant.

A load strobe captures a new configuration: the mode, a base address, a stride and a transform size. The same strobe restarts the sequence at the base address. The configuration can be replaced at any moment while the surrounding datapath is running. Between loads, the address changes only in cycles where the step enable is high.

Top module: `dsp_agu`

## Requirements
- R1: After reset `addr_out` is 0. The active configuration is increment mode, base 0, stride 1, transform size exponent 10.
- R2: On a clock edge with `cfg_load` high, the configuration inputs are captured and the internal step counter is cleared. From the next cycle `addr_out` equals `cfg_base`. The mode encoding on `cfg_mode` is 0 = increment, 1 = decrement, 2 = bit-reversed, 3 = table lookup.
- R3: Values on `cfg_mode`, `cfg_base`, `cfg_stride` and `cfg_log2n` have no effect at an edge where `cfg_load` is low.
- R4: In increment mode, each enabled edge sets `addr_out` to the previous `addr_out` plus the stride, modulo 1024.
- R5: In decrement mode, each enabled edge sets `addr_out` to the previous `addr_out` minus the stride, modulo 1024.
- R6: In bit-reversed mode, each enabled edge advances a 10-bit step counter by one, wrapping modulo 1024. `addr_out` becomes base plus a value formed from the counter, modulo 1024. In that value, the low k counter bits appear in reversed order and the upper bits are unchanged, where k is the loaded exponent.
- R7: A loaded exponent above 10 is treated as 10. An exponent of 0 reverses nothing, so the bit-reversed mode then counts up from base by one.
- R8: In table mode, each enabled edge sets `addr_out` to base plus bits 15 down to 6 of `lut_data`, modulo 1024.
- R9: On an edge with `step_en` low and `cfg_load` low, `addr_out` keeps its value.
- R10: When `cfg_load` and `step_en` are both high at one edge, the load takes effect and the step is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Captures the configuration and restarts the sequence |
| cfg_mode | input | 2 | Addressing mode to load |
| cfg_base | input | 10 | Base address to load |
| cfg_stride | input | 10 | Step size for the linear modes |
| cfg_log2n | input | 4 | Exponent of the bit-reversal size |
| step_en | input | 1 | Advances the sequence by one step |
| lut_data | input | 16 | Data word that indexes the table in table mode |
| addr_out | output | 10 | Registered memory address |

## Verification
Each result comes from one register stage. A load or an enabled step applied before edge n appears on `addr_out` just after edge n. The bench drives inputs on the falling edge and samples one time unit after the rising edge, so it sees exactly that cycle's result. The bench keeps its own model of the address, the counter and the configuration and updates it once per driven edge. Each check therefore compares against the value that a single edge should have produced.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int AGU_ADDR_W = 10;
  localparam int AGU_DATA_W = 16;

  typedef enum logic [1:0] {
    AGU_INC  = 2'd0,
    AGU_DEC  = 2'd1,
    AGU_BREV = 2'd2,
    AGU_LUT  = 2'd3
  } agu_mode_e;
endpackage

// File: rtl/agu_cfg_regs.sv
module agu_cfg_regs
  import agu_pkg::*;
#(
  parameter int ADDR_W = AGU_ADDR_W,
  parameter int LOG_W  = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [LOG_W-1:0]  log2n_i,
  output agu_mode_e         mode_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] stride_o,
  output logic [LOG_W-1:0]  log2n_o
);
  localparam logic [LOG_W-1:0] MAX_LOG = LOG_W'(ADDR_W);

  function automatic logic [LOG_W-1:0] clamp_log(input logic [LOG_W-1:0] v);
    return (v > MAX_LOG) ? MAX_LOG : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o   <= AGU_INC;
      base_o   <= '0;
      stride_o <= ADDR_W'(1);
      log2n_o  <= MAX_LOG;
    end else if (load_i) begin
      mode_o   <= agu_mode_e'(mode_i);
      base_o   <= base_i;
      stride_o <= stride_i;
      log2n_o  <= clamp_log(log2n_i);
    end
  end

  AST_LOG_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    log2n_o <= MAX_LOG) else $error("log2n above limit"); // R7
endmodule

// File: rtl/agu_seq.sv
module agu_seq
  import agu_pkg::*;
#(
  parameter int ADDR_W = AGU_ADDR_W,
  parameter int DATA_W = AGU_DATA_W,
  parameter int LOG_W  = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] load_base_i,
  input  agu_mode_e         mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [LOG_W-1:0]  log2n_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] cnt_o
);
  function automatic logic [ADDR_W-1:0] brev_low(input logic [ADDR_W-1:0] v,
                                                 input logic [LOG_W-1:0] k);
    logic [ADDR_W-1:0] r;
    r = v;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i < int'(k)) r[i] = v[int'(k) - 1 - i];
    end
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] next_addr(
    input agu_mode_e         m,
    input logic [ADDR_W-1:0] cur,
    input logic [ADDR_W-1:0] base,
    input logic [ADDR_W-1:0] stride,
    input logic [ADDR_W-1:0] cnt_nx,
    input logic [LOG_W-1:0]  k,
    input logic [DATA_W-1:0] d
  );
    case (m)
      AGU_INC:  return cur + stride;
      AGU_DEC:  return cur - stride;
      AGU_BREV: return base + brev_low(cnt_nx, k);
      default:  return base + d[DATA_W-1 -: ADDR_W];
    endcase
  endfunction

  logic [ADDR_W-1:0] cnt_q, addr_q;
  logic [ADDR_W-1:0] cnt_nx;
  logic              adv;

  assign cnt_nx = cnt_q + ADDR_W'(1);
  assign adv    = step_i && !load_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      cnt_q  <= '0;
      addr_q <= load_base_i;
    end else if (step_i) begin
      cnt_q  <= cnt_nx;
      addr_q <= next_addr(mode_i, addr_q, base_i, stride_i, cnt_nx, log2n_i, data_i);
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == '0) else $error("counter not cleared"); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> cnt_q == $past(cnt_q) + ADDR_W'(1)) else $error("counter step"); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(cnt_q)) else $error("counter moved"); // R9
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
  import agu_pkg::*;
#(
  parameter int ADDR_W = AGU_ADDR_W,
  parameter int DATA_W = AGU_DATA_W,
  parameter int LOG_W  = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [1:0]        cfg_mode,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_stride,
  input  logic [LOG_W-1:0]  cfg_log2n,
  input  logic              step_en,
  input  logic [DATA_W-1:0] lut_data,
  output logic [ADDR_W-1:0] addr_out
);
  agu_mode_e         mode_q;
  logic [ADDR_W-1:0] base_q, stride_q, cnt_w;
  logic [LOG_W-1:0]  log2n_q;
  logic              step_taken;

  assign step_taken = step_en && !cfg_load;

  agu_cfg_regs #(.ADDR_W(ADDR_W), .LOG_W(LOG_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .load_i(cfg_load), .mode_i(cfg_mode),
    .base_i(cfg_base), .stride_i(cfg_stride), .log2n_i(cfg_log2n),
    .mode_o(mode_q), .base_o(base_q), .stride_o(stride_q), .log2n_o(log2n_q)
  );

  agu_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOG_W(LOG_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .load_i(cfg_load), .step_i(step_en),
    .load_base_i(cfg_base), .mode_i(mode_q), .base_i(base_q),
    .stride_i(stride_q), .log2n_i(log2n_q), .data_i(lut_data),
    .addr_o(addr_out), .cnt_o(cnt_w)
  );

  AST_LOAD_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> addr_out == $past(cfg_base)) else $error("load base"); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !cfg_load) |=> $stable(addr_out)) else $error("idle moved"); // R9
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_taken && mode_q == AGU_INC) |=> addr_out == $past(addr_out + stride_q))
    else $error("inc step"); // R4
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_taken && mode_q == AGU_DEC) |=> addr_out == $past(addr_out - stride_q))
    else $error("dec step"); // R5
  AST_BREV_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (step_taken && mode_q == AGU_BREV && cnt_w == '0 && log2n_q == LOG_W'(0))
    |=> addr_out == $past(base_q) + ADDR_W'(1)) else $error("brev k0"); // R7
  AST_LUT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (step_taken && mode_q == AGU_LUT)
    |=> addr_out == $past(base_q + lut_data[DATA_W-1 -: ADDR_W])) else $error("lut"); // R8
endmodule

// File: tb/dsp_agu_tb_top.sv
module dsp_agu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [9:0]  cfg_base = '0;
  logic [9:0]  cfg_stride = '0;
  logic [3:0]  cfg_log2n = '0;
  logic        step_en = 1'b0;
  logic [15:0] lut_data = '0;
  logic [9:0]  addr_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [1:0] m_mode;
  logic [9:0] m_base, m_stride, m_addr, m_cnt;
  int         m_k;

  always #5 clk = ~clk;

  dsp_agu dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_base(cfg_base), .cfg_stride(cfg_stride), .cfg_log2n(cfg_log2n),
    .step_en(step_en), .lut_data(lut_data), .addr_out(addr_out)
  );

  function automatic logic [9:0] rev_k(input logic [9:0] v, input int k);
    logic [9:0] r;
    r = v;
    for (int j = 0; j < k; j++) r[k - 1 - j] = v[j];
    return r;
  endfunction

  task automatic check(input logic [9:0] exp, input string req);
    checks++;
    if (addr_out !== exp) begin
      errors++;
      $display("FAIL %s: addr_out=%0d expected=%0d", req, addr_out, exp);
    end
  endtask

  // one edge: drive on falling edge, sample just after rising edge
  task automatic edge_drive(input bit ld, input bit en, input logic [1:0] md,
                            input logic [9:0] b, input logic [9:0] s,
                            input logic [3:0] k, input logic [15:0] d);
    @(negedge clk);
    cfg_load = ld; step_en = en; cfg_mode = md; cfg_base = b;
    cfg_stride = s; cfg_log2n = k; lut_data = d;
    if (ld) begin
      m_mode = md; m_base = b; m_stride = s; m_k = (k > 10) ? 10 : int'(k);
      m_cnt = '0; m_addr = b;
    end else if (en) begin
      m_cnt = m_cnt + 10'd1;
      case (m_mode)
        2'd0: m_addr = m_addr + m_stride;
        2'd1: m_addr = m_addr - m_stride;
        2'd2: m_addr = m_base + rev_k(m_cnt, m_k);
        default: m_addr = m_base + d[15:6];
      endcase
    end
    @(posedge clk);
    #1;
    @(negedge clk);
    cfg_load = 1'b0; step_en = 1'b0;
  endtask

  task automatic load(input logic [1:0] md, input logic [9:0] b,
                      input logic [9:0] s, input logic [3:0] k, input string req);
    edge_drive(1'b1, 1'b0, md, b, s, k, 16'h0);
    check(m_base, req);
  endtask

  task automatic step(input logic [15:0] d, input string req);
    edge_drive(1'b0, 1'b1, cfg_mode, cfg_base, cfg_stride, cfg_log2n, d);
    check(m_addr, req);
  endtask

  task automatic t_reset;
    m_mode = 2'd0; m_base = '0; m_stride = 10'd1; m_k = 10; m_cnt = '0; m_addr = '0;
    check(10'd0, "R1 reset address");
    step(16'h0, "R1 default stride 1");
  endtask

  task automatic t_ignore_cfg;
    // cfg inputs change without load; default increment by 1 continues
    edge_drive(1'b0, 1'b1, 2'd3, 10'd500, 10'd77, 4'd2, 16'hFFFF);
    check(m_addr, "R3 cfg ignored without load");
    check(10'd2, "R3 still stride 1 from base 0");
  endtask

  task automatic t_inc;
    load(2'd0, 10'd1000, 10'd10, 4'd0, "R2 load inc");
    step(16'h0, "R4 inc 1010");
    step(16'h0, "R4 inc 1020");
    step(16'h0, "R4 inc wraps");
    check(10'd6, "R4 wrap value 6");
  endtask

  task automatic t_dec;
    load(2'd1, 10'd5, 10'd3, 4'd0, "R2 load dec");
    step(16'h0, "R5 dec 2");
    step(16'h0, "R5 dec wraps");
    check(10'd1023, "R5 wrap value 1023");
  endtask

  task automatic t_hold;
    edge_drive(1'b0, 1'b0, 2'd0, 10'd0, 10'd0, 4'd0, 16'h0);
    check(m_addr, "R9 hold without enable");
    edge_drive(1'b0, 1'b0, 2'd2, 10'd9, 10'd9, 4'd9, 16'h1234);
    check(10'd1023, "R9 hold value");
  endtask

  task automatic t_brev;
    load(2'd2, 10'd100, 10'd0, 4'd3, "R2 load brev");
    for (int i = 0; i < 9; i++) step(16'h0, "R6 brev k=3");
    load(2'd2, 10'd0, 10'd0, 4'd10, "R2 load brev full");
    step(16'h0, "R6 brev k=10 first");
    check(10'd512, "R6 k=10 step1 -> 512");
    step(16'h0, "R6 brev k=10 second");
    check(10'd256, "R6 k=10 step2 -> 256");
  endtask

  task automatic t_clamp;
    load(2'd2, 10'd0, 10'd0, 4'd15, "R7 load k=15");
    step(16'h0, "R7 clamp acts as 10");
    check(10'd512, "R7 clamp value 512");
    load(2'd2, 10'd50, 10'd0, 4'd0, "R7 load k=0");
    step(16'h0, "R7 k=0 counts");
    check(10'd51, "R7 k=0 value 51");
    step(16'h0, "R7 k=0 value 52");
  endtask

  task automatic t_lut;
    load(2'd3, 10'd16, 10'd0, 4'd0, "R2 load lut");
    step(16'h0040, "R8 lut index 1");
    check(10'd17, "R8 lut value 17");
    step(16'hFFC0, "R8 lut wraps");
    check(10'd15, "R8 lut value 15");
    step(16'h003F, "R8 lut low bits ignored");
  endtask

  task automatic t_priority;
    load(2'd0, 10'd200, 10'd4, 4'd0, "R2 load inc 200");
    step(16'h0, "R4 inc 204");
    edge_drive(1'b1, 1'b1, 2'd0, 10'd300, 10'd4, 4'd0, 16'h0);
    check(10'd300, "R10 load beats step");
    step(16'h0, "R10 step after load");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: addr_out=%0d expected=completion", addr_out);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_ignore_cfg();
    t_inc();
    t_dec();
    t_hold();
    t_brev();
    t_clamp();
    t_lut();
    t_priority();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule